// File: doc/BRIEF.md
# BCD Up/Down Decade Counter Digit

This block holds one decimal digit that steps between 0 and 9 under two separate strobes, one counting up and one counting down. It runs on a single system clock. Both strobes are treated as asynchronous. Each one passes through a synchronizer and an edge detector before it reaches the digit register, so every rising edge on a strobe moves the count by exactly one.

The digit can be forced to zero with an active-high clear. It can also be preset from a 4-bit data input with an active-low load. Two active-low pulse outputs flag the wraps: carry on the step from 9 to 0, and borrow on the step from 0 to 9. When a carry or borrow output feeds the matching strobe of the next higher digit, several digits form a presettable multi-digit counter or countdown timer.

Top module: `bcd_updown_digit`

## Requirements
- R1: While reset is held and right after it, the count is 0 and both carry_n and borrow_n are high.
- R2: A rising edge on up_strobe adds one to a count of 0 to 8. The strobe is first seen high at clock edge k, and the new count appears after clock edge k+2.
- R3: A rising edge on down_strobe subtracts one from a count of 1 to 9, with the same latency as R2.
- R4: An up step from a count of 9 or more gives 0. In that case carry_n is low for exactly one clock, in the same cycle in which the count first reads 0.
- R5: A down step from 0 gives 9. In that case borrow_n is low for exactly one clock, in the same cycle in which the count first reads 9.
- R6: When clear is high at a clock edge, the count is 0 after that edge. Clear takes priority over load and over any strobe edge.
- R7: When load_n is low and clear is low at a clock edge, the count takes preset_d after that edge. Load takes priority over a strobe edge arriving in the same cycle, and that strobe edge is dropped.
- R8: When synchronized rising edges of up_strobe and down_strobe fall in the same cycle, the count holds and neither carry_n nor borrow_n goes low.
- R9: A down step from a loaded non-decimal value of 10 to 15 gives that value minus one, and borrow_n stays high.
- R10: A strobe held high moves the count by one step only. Another step needs the strobe to go low and then high again.
- R11: carry_n and borrow_n are never low in the same cycle. Neither goes low except on a counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_strobe | input | 1 | Asynchronous count-up strobe; acts on its rising edge |
| down_strobe | input | 1 | Asynchronous count-down strobe; acts on its rising edge |
| clear | input | 1 | Synchronous active-high clear to zero |
| load_n | input | 1 | Synchronous active-low preset enable |
| preset_d | input | 4 | Preset value (bit weights 1, 2, 4, 8) |
| count_q | output | 4 | Current digit (bit weights 1, 2, 4, 8) |
| carry_n | output | 1 | Active-low one-clock pulse on the 9 to 0 wrap |
| borrow_n | output | 1 | Active-low one-clock pulse on the 0 to 9 wrap |

## Verification
Two kinds of event can fall in one cycle. The first is a load or clear landing in the same cycle as a synchronized strobe edge. The bench provokes this by raising up_strobe and then lowering load_n exactly two clocks later, which is the cycle in which the edge has worked through the synchronizer. It then checks that the preset value survives and that no carry pulse appears. The second is an up edge and a down edge falling together. The bench raises both strobes at the same instant and judges the outcome by an unchanged count with both wrap outputs held high. Each of these checks comes after a sweep of all sixteen load values through single up and down steps, with the expected results computed arithmetically.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  parameter int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Returns {wrapped, next} for one upward step.
  function automatic logic [DIGIT_W:0] step_up(input digit_t q, input digit_t top);
    if (q >= top) return {1'b1, {DIGIT_W{1'b0}}};
    return {1'b0, digit_t'(q + 1'b1)};
  endfunction

  // Returns {wrapped, next} for one downward step.
  function automatic logic [DIGIT_W:0] step_down(input digit_t q, input digit_t top);
    if (q == '0) return {1'b1, top};
    return {1'b0, digit_t'(q - 1'b1)};
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~prev;

  // R10: an edge pulse can never last two cycles
  p_single_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/digit_core.sv
module digit_core
  import bcd_digit_pkg::*;
#(
  parameter int MAX_DIGIT = 9
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   load_n,
  input  digit_t preset_d,
  input  logic   up_ev,
  input  logic   dn_ev,
  output digit_t count_q,
  output logic   carry_n,
  output logic   borrow_n
);
  localparam digit_t TOP = digit_t'(MAX_DIGIT);

  logic             do_clear, do_load, do_up, do_dn;
  logic [DIGIT_W:0] up_res, dn_res;
  logic             up_wrap, dn_wrap;

  assign do_clear = clear;
  assign do_load  = !clear && !load_n;
  assign do_up    = !do_clear && !do_load && up_ev && !dn_ev;
  assign do_dn    = !do_clear && !do_load && dn_ev && !up_ev;
  assign up_res   = step_up(count_q, TOP);
  assign dn_res   = step_down(count_q, TOP);
  assign up_wrap  = do_up && up_res[DIGIT_W];
  assign dn_wrap  = do_dn && dn_res[DIGIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= !up_wrap;
      borrow_n <= !dn_wrap;
      if (do_clear)     count_q <= '0;
      else if (do_load) count_q <= preset_d;
      else if (do_up)   count_q <= up_res[DIGIT_W-1:0];
      else if (do_dn)   count_q <= dn_res[DIGIT_W-1:0];
    end
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0);
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> count_q == $past(preset_d));
  p_carry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> count_q == '0);
  p_carry_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |=> carry_n);
  p_borrow_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> count_q == TOP);
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ev && dn_ev && !clear && load_n) |=> ($stable(count_q) && carry_n && borrow_n));
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!carry_n && !borrow_n));
  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_ev || dn_ev) |=> (carry_n && borrow_n));
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_digit_pkg::*;
#(
  parameter int MAX_DIGIT   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_strobe,
  input  logic               down_strobe,
  input  logic               clear,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] preset_d,
  output logic [DIGIT_W-1:0] count_q,
  output logic               carry_n,
  output logic               borrow_n
);
  localparam int N_STROBES = 2;

  logic [N_STROBES-1:0] raw;
  logic [N_STROBES-1:0] edge_ev;

  assign raw = {down_strobe, up_strobe};

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw[g]), .rise(edge_ev[g])
    );
  end

  digit_core #(.MAX_DIGIT(MAX_DIGIT)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n),
    .preset_d(preset_d), .up_ev(edge_ev[0]), .dn_ev(edge_ev[1]),
    .count_q(count_q), .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: tb/tb_bcd_updown_digit.sv
`timescale 1ns/1ps
module tb_bcd_updown_digit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_strobe = 1'b0, down_strobe = 1'b0, clear = 1'b0, load_n = 1'b1;
  logic [3:0] preset_d = '0;
  logic [3:0] count_q;
  logic carry_n, borrow_n;
  int total = 0, bad = 0;
  int n_carry, n_borrow;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_updown_digit dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample_pulses();
    @(negedge clk);
    if (!carry_n) n_carry++;
    if (!borrow_n) n_borrow++;
    if (!carry_n && !borrow_n) begin
      bad++;
      $display("FAIL R11 actual=both_low expected=exclusive");
    end
  endtask

  task automatic load_val(input int v);
    @(negedge clk); preset_d = 4'(v); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
  endtask

  // drive strobes, watch pulses, release and settle
  task automatic pulse(input bit u, input bit d, input int hold);
    n_carry = 0; n_borrow = 0;
    @(negedge clk); up_strobe = u; down_strobe = d;
    repeat (hold) sample_pulses();
    up_strobe = 1'b0; down_strobe = 1'b0;
    repeat (5) sample_pulses();
  endtask

  function automatic int exp_up(input int v);
    return (v >= 9) ? 0 : v + 1;
  endfunction

  function automatic int exp_dn(input int v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count_q), 0);
    chk("R1 carry_n", int'(carry_n), 1);
    chk("R1 borrow_n", int'(borrow_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(count_q), 0);

    // R2 latency: strobe seen at edge k, new count after edge k+2
    load_val(4);
    @(negedge clk); up_strobe = 1'b1;
    @(negedge clk); chk("R2 latency k", int'(count_q), 4);
    @(negedge clk); chk("R2 latency k+1", int'(count_q), 4);
    @(negedge clk); chk("R2 latency k+2", int'(count_q), 5);
    up_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // Sweep all loadable values
    for (int v = 0; v < 16; v++) begin
      load_val(v);
      chk("R7 load", int'(count_q), v);
      pulse(1, 0, 4);
      chk(v >= 9 ? "R4 up wrap" : "R2 up step", int'(count_q), exp_up(v));
      chk("R4 carry pulses", n_carry, (v >= 9) ? 1 : 0);
      chk("R11 no borrow on up", n_borrow, 0);
      load_val(v);
      pulse(0, 1, 4);
      chk(v == 0 ? "R5 down wrap" : (v > 9 ? "R9 non-decimal down" : "R3 down step"),
          int'(count_q), exp_dn(v));
      chk(v > 9 ? "R9 no borrow" : "R5 borrow pulses", n_borrow, (v == 0) ? 1 : 0);
      chk("R11 no carry on down", n_carry, 0);
    end

    // R10: held strobe steps once
    load_val(2);
    pulse(1, 0, 12);
    chk("R10 held up", int'(count_q), 3);
    pulse(0, 1, 12);
    chk("R10 held down", int'(count_q), 2);

    // R8: simultaneous edges
    load_val(9);
    pulse(1, 1, 4);
    chk("R8 hold count", int'(count_q), 9);
    chk("R8 no carry", n_carry, 0);
    load_val(0);
    pulse(1, 1, 4);
    chk("R8 hold at 0", int'(count_q), 0);
    chk("R8 no borrow", n_borrow, 0);

    // R7: load coinciding with synchronized up edge
    load_val(9);
    n_carry = 0;
    @(negedge clk); up_strobe = 1'b1; preset_d = 4'd6;
    @(negedge clk);
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1; up_strobe = 1'b0;
    if (!carry_n) n_carry++;
    repeat (4) sample_pulses();
    chk("R7 load beats edge", int'(count_q), 6);
    chk("R7 edge dropped no carry", n_carry, 0);

    // R6: clear beats load and edge
    load_val(7);
    @(negedge clk); clear = 1'b1; load_n = 1'b0; preset_d = 4'd3;
    @(negedge clk); clear = 1'b0; load_n = 1'b1;
    chk("R6 clear over load", int'(count_q), 0);
    load_val(5);
    @(negedge clk); up_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0; up_strobe = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 clear over edge", int'(count_q), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule